// File: doc/BRIEF.md
# Branch and Vector Target Unit

This block computes where an 8-bit core goes next after a control-transfer instruction. For each instruction it receives a decoded transfer kind, the address of the instruction, the opcode, up to two operand bytes, the four status flags, the accumulator, a tested memory byte and the zero result of a fused compare or decrement. It decides whether the transfer is taken. It also produces the destination address and the sequential fall-through address.

Relative branches add a sign-extended 8-bit offset to the address of the next instruction. The next instruction is two or three bytes on, depending on the instruction length. Upper-page calls jump into the last 256-byte page. Table calls produce the address of a two-byte vector slot picked by the opcode's upper nibble. The core pushes its return address and fetches the vector on its own.

A strobe launches an evaluation, and the result appears registered one clock later.

Top module: `xfer_target_unit`

## Requirements
- R1: After reset `outValid`, `outTaken`, `outTarget` and `outFall` are zero. `outValid` is high exactly in the cycle after a cycle with `inValid` high. Without `inValid` the three result outputs keep their values whatever the other inputs do.
- R2: Kind 0 (flag branch, 2 bytes) picks a flag with opcode bits 7:6: 0 = N, 1 = V, 2 = C, 3 = Z. It is taken when that flag equals opcode bit 5.
- R3: Every 2-byte relative form targets `pc + 2 + sext(op1)` and reports `pc + 2` as fall-through. Offset FEh therefore targets `pc` itself.
- R4: Kind 1 (unconditional branch, 2 bytes) is always taken.
- R5: Kind 2 (accumulator bit test, 2 bytes) tests `accVal` bit number opcode[7:5]. Opcode bit 4 = 1 branches when the bit is 1, and 0 branches when it is 0.
- R6: Kind 3 (memory bit test, 3 bytes) tests `memVal` the same way as R5. It targets `pc + 3 + sext(op2)` with fall-through `pc + 3`.
- R7: Kind 4 (fused compare/decrement, 3 bytes, offset in op2) and kind 5 (fused register decrement, 2 bytes, offset in op1) are taken exactly when `cmpZero` is 0.
- R8: Kind 6 (upper-page call) is always taken, targets FF00h + op1, and has fall-through `pc + 2`.
- R9: Kind 7 (table call) is always taken, targets FFDEh − 2·opcode[7:4], and has fall-through `pc + 1`.
- R10: All address sums wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Evaluate strobe |
| inKind | input | 3 | Transfer kind (see R2–R9) |
| pc | input | 16 | Address of the instruction's first byte |
| opcode | input | 8 | Opcode byte |
| op1 | input | 8 | First operand byte |
| op2 | input | 8 | Second operand byte |
| flagN | input | 1 | Negative flag |
| flagV | input | 1 | Overflow flag |
| flagC | input | 1 | Carry flag |
| flagZ | input | 1 | Zero flag |
| accVal | input | 8 | Accumulator value |
| memVal | input | 8 | Tested memory byte |
| cmpZero | input | 1 | Zero result of fused compare or decrement |
| outValid | output | 1 | Result valid, one cycle after the strobe |
| outTaken | output | 1 | Transfer taken |
| outTarget | output | 16 | Destination address |
| outFall | output | 16 | Fall-through address |

## Verification
The bench sweeps all 256 offsets against every flag-select, polarity and flag pattern. This catches a design that sign-extends wrongly, uses the wrong base length or reads the wrong flag; each of these shows up at offsets 7Fh/80h or FEh. Bit tests run over every accumulator and memory value and every bit number, so a bit index taken from the wrong opcode field, or an inverted polarity, makes half the cases mismatch. Branches placed at FFFEh check that a carry out of the 16-bit sum is dropped. All sixteen table slots are checked, which exposes a slot stride or direction error at the FFC0h/FFDEh ends. Hold cycles with changing inputs catch a result register that loads without the strobe.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    K_FLAG  = 3'd0,
    K_BRA   = 3'd1,
    K_ABIT  = 3'd2,
    K_MBIT  = 3'd3,
    K_FUSE3 = 3'd4,
    K_FUSE2 = 3'd5,
    K_PCALL = 3'd6,
    K_TCALL = 3'd7
  } xferKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;      // capture a new result
    logic       taken;     // evaluated condition
    logic [1:0] len;       // instruction length in bytes
    logic       relHigh;   // offset comes from the second operand
    logic       upage;     // absolute upper-page target
    logic       vector;    // table-slot target
  } xferCtrl_t;

endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              inValid,
  input  logic [2:0]        inKind,
  input  logic [2:0]        opTop,      // opcode bits 7:5
  input  logic              opPol,      // opcode bit 4
  input  logic              flagN,
  input  logic              flagV,
  input  logic              flagC,
  input  logic              flagZ,
  input  logic [DATA_W-1:0] accVal,
  input  logic [DATA_W-1:0] memVal,
  input  logic              cmpZero,
  output xferCtrl_t         ctrl
);

  localparam int BIT_W = $clog2(DATA_W);

  logic [BIT_W-1:0] bitIdx;
  logic flagSel;
  logic accBit;
  logic memBit;

  assign bitIdx = BIT_W'(opTop);

  always_comb begin
    unique case (opTop[2:1])
      2'd0: flagSel = flagN;
      2'd1: flagSel = flagV;
      2'd2: flagSel = flagC;
      default: flagSel = flagZ;
    endcase
  end

  assign accBit = accVal[bitIdx];
  assign memBit = memVal[bitIdx];

  always_comb begin
    ctrl         = '0;
    ctrl.load    = inValid;
    ctrl.len     = 2'd2;
    unique case (xferKind_e'(inKind))
      K_FLAG:  ctrl.taken = (flagSel == opTop[0]);
      K_BRA:   ctrl.taken = 1'b1;
      K_ABIT:  ctrl.taken = (accBit == opPol);
      K_MBIT: begin
        ctrl.taken   = (memBit == opPol);
        ctrl.len     = 2'd3;
        ctrl.relHigh = 1'b1;
      end
      K_FUSE3: begin
        ctrl.taken   = ~cmpZero;
        ctrl.len     = 2'd3;
        ctrl.relHigh = 1'b1;
      end
      K_FUSE2: ctrl.taken = ~cmpZero;
      K_PCALL: begin
        ctrl.taken = 1'b1;
        ctrl.upage = 1'b1;
      end
      default: begin
        ctrl.taken  = 1'b1;
        ctrl.len    = 2'd1;
        ctrl.vector = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import xfer_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          NIB_W       = 4,
  parameter [ADDR_W-1:0] UPAGE_BASE  = 16'hFF00,
  parameter [ADDR_W-1:0] VECTOR_TOP  = 16'hFFDE
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferCtrl_t         ctrl,
  input  logic [ADDR_W-1:0] pc,
  input  logic [NIB_W-1:0]  slot,
  input  logic [DATA_W-1:0] op1,
  input  logic [DATA_W-1:0] op2,
  output logic              outValid,
  output logic              outTaken,
  output logic [ADDR_W-1:0] outTarget,
  output logic [ADDR_W-1:0] outFall
);

  localparam int EXT_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] relByte;
  logic [ADDR_W-1:0] relExt;
  logic [ADDR_W-1:0] fallNext;
  logic [ADDR_W-1:0] relTarget;
  logic [ADDR_W-1:0] upTarget;
  logic [ADDR_W-1:0] vecTarget;
  logic [ADDR_W-1:0] targetNext;

  assign relByte   = ctrl.relHigh ? op2 : op1;
  assign relExt    = {{EXT_W{relByte[DATA_W-1]}}, relByte};
  assign fallNext  = pc + ADDR_W'(ctrl.len);
  assign relTarget = fallNext + relExt;
  assign upTarget  = UPAGE_BASE | ADDR_W'(op1);
  assign vecTarget = VECTOR_TOP - ADDR_W'({slot, 1'b0});

  always_comb begin
    if (ctrl.vector)     targetNext = vecTarget;
    else if (ctrl.upage) targetNext = upTarget;
    else                 targetNext = relTarget;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outTaken  <= 1'b0;
      outTarget <= '0;
      outFall   <= '0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) begin
        outTaken  <= ctrl.taken;
        outTarget <= targetNext;
        outFall   <= fallNext;
      end
    end
  end

endmodule

// File: rtl/xfer_target_unit.sv
module xfer_target_unit
  import xfer_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter [ADDR_W-1:0] UPAGE_BASE = 16'hFF00,
  parameter [ADDR_W-1:0] VECTOR_TOP = 16'hFFDE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        inKind,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] opcode,
  input  logic [DATA_W-1:0] op1,
  input  logic [DATA_W-1:0] op2,
  input  logic              flagN,
  input  logic              flagV,
  input  logic              flagC,
  input  logic              flagZ,
  input  logic [DATA_W-1:0] accVal,
  input  logic [DATA_W-1:0] memVal,
  input  logic              cmpZero,
  output logic              outValid,
  output logic              outTaken,
  output logic [ADDR_W-1:0] outTarget,
  output logic [ADDR_W-1:0] outFall
);

  localparam int NIB_W = DATA_W / 2;

  xferCtrl_t ctrl;

  xfer_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .inValid (inValid),
    .inKind  (inKind),
    .opTop   (opcode[DATA_W-1 -: 3]),
    .opPol   (opcode[DATA_W-4]),
    .flagN   (flagN),
    .flagV   (flagV),
    .flagC   (flagC),
    .flagZ   (flagZ),
    .accVal  (accVal),
    .memVal  (memVal),
    .cmpZero (cmpZero),
    .ctrl    (ctrl)
  );

  xfer_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NIB_W      (NIB_W),
    .UPAGE_BASE (UPAGE_BASE),
    .VECTOR_TOP (VECTOR_TOP)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .pc        (pc),
    .slot      (opcode[DATA_W-1 -: NIB_W]),
    .op1       (op1),
    .op2       (op2),
    .outValid  (outValid),
    .outTaken  (outTaken),
    .outTarget (outTarget),
    .outFall   (outFall)
  );

endmodule

// File: rtl/xfer_target_unit_chk.sv
module xfer_target_unit_chk
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [2:0]        inKind,
  input logic [ADDR_W-1:0] pc,
  input logic [DATA_W-1:0] op1,
  input logic              cmpZero,
  input logic              outValid,
  input logic              outTaken,
  input logic [ADDR_W-1:0] outTarget,
  input logic [ADDR_W-1:0] outFall
);

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_hold_target_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outTarget) && $stable(outFall) && $stable(outTaken)));

  assert_bra_taken_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inKind == K_BRA) |=> outTaken);

  assert_fused_cond_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (inKind == K_FUSE3 || inKind == K_FUSE2)) |=> (outTaken == !$past(cmpZero)));

  assert_upage_target_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inKind == K_PCALL) |=>
      (outTaken && outTarget[ADDR_W-1:DATA_W] == '1 && outTarget[DATA_W-1:0] == $past(op1)));

  assert_vector_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inKind == K_TCALL) |=>
      (outTaken && !outTarget[0] && outTarget >= 16'hFFC0 && outTarget <= 16'hFFDE
       && outFall == $past(pc) + 16'd1));

  assert_long_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (inKind == K_MBIT || inKind == K_FUSE3)) |=> (outFall == $past(pc) + 16'd3));

endmodule

bind xfer_target_unit xfer_target_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inKind    (inKind),
  .pc        (pc),
  .op1       (op1),
  .cmpZero   (cmpZero),
  .outValid  (outValid),
  .outTaken  (outTaken),
  .outTarget (outTarget),
  .outFall   (outFall)
);

// File: tb/xfer_target_unit_tb_top.sv
module xfer_target_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  inKind = '0;
  logic [15:0] pc = '0;
  logic [7:0]  opcode = '0, op1 = '0, op2 = '0, accVal = '0, memVal = '0;
  logic        flagN = 0, flagV = 0, flagC = 0, flagZ = 0, cmpZero = 0;
  logic        outValid, outTaken;
  logic [15:0] outTarget, outFall;

  int vecCount = 0;
  int errCount = 0;
  logic [15:0] lastTarget;

  always #5 clk = ~clk;

  xfer_target_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inKind(inKind), .pc(pc),
    .opcode(opcode), .op1(op1), .op2(op2), .flagN(flagN), .flagV(flagV),
    .flagC(flagC), .flagZ(flagZ), .accVal(accVal), .memVal(memVal),
    .cmpZero(cmpZero), .outValid(outValid), .outTaken(outTaken),
    .outTarget(outTarget), .outFall(outFall)
  );

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    vecCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual v/t/target/fall=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a negedge, compare at the next negedge (one register stage)
  task automatic apply(input logic [2:0] k, input logic [15:0] p, input logic [7:0] opc,
                       input logic [7:0] a1, input logic [7:0] a2, input logic [3:0] nvcz,
                       input logic [7:0] acc, input logic [7:0] mem, input logic cz,
                       input string tag);
    logic [15:0] len, base, tgt;
    logic [7:0]  rel;
    logic        tk, fl, bitv;
    inValid = 1'b1; inKind = k; pc = p; opcode = opc; op1 = a1; op2 = a2;
    {flagN, flagV, flagC, flagZ} = nvcz; accVal = acc; memVal = mem; cmpZero = cz;
    len = (k == 3'd3 || k == 3'd4) ? 16'd3 : (k == 3'd7 ? 16'd1 : 16'd2);
    rel = (len == 16'd3) ? a2 : a1;
    base = p + len;
    tgt = base + {{8{rel[7]}}, rel};
    fl = nvcz[3 - opc[7:6]];
    case (k)
      3'd0: tk = (fl == opc[5]);
      3'd2: begin bitv = acc[opc[7:5]]; tk = (bitv == opc[4]); end
      3'd3: begin bitv = mem[opc[7:5]]; tk = (bitv == opc[4]); end
      3'd4, 3'd5: tk = !cz;
      default: tk = 1'b1;
    endcase
    if (k == 3'd6) tgt = 16'hFF00 + {8'h00, a1};
    if (k == 3'd7) tgt = 16'hFFDE - 16'd2 * {12'h000, opc[7:4]};
    @(negedge clk);
    check(tag, {outValid, outTaken, outTarget, outFall}, {1'b1, tk, tgt, base});
    lastTarget = tgt;
  endtask

  initial begin
    #2_000_000;
    errCount++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {outValid, outTaken, outTarget, outFall}, 34'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle", {outValid, outTaken, outTarget, outFall}, 34'd0);

    // R2 R3: flag branches, every flag-select/polarity, flag pattern, offset
    for (int o = 0; o < 8; o++)
      for (int f = 0; f < 16; f++)
        for (int r = 0; r < 256; r++)
          apply(3'd0, 16'h4000 + 16'(r * 7), 8'(o << 5), 8'(r), 8'h00, 4'(f), 8'h00, 8'h00,
                1'b0, "R2 R3 flag branch");

    // R4 R3 R10: unconditional, including self loop and wrap at top of memory
    for (int r = 0; r < 256; r++) begin
      apply(3'd1, 16'h8100, 8'h2F, 8'(r), 8'h00, 4'h0, 8'h00, 8'h00, 1'b0, "R4 R3 bra");
      apply(3'd1, 16'hFFFE, 8'h2F, 8'(r), 8'h00, 4'h0, 8'h00, 8'h00, 1'b0, "R10 wrap");
    end

    // R5: accumulator bit test over every value, bit number and polarity
    for (int b = 0; b < 16; b++)
      for (int v = 0; v < 256; v++)
        apply(3'd2, 16'h1230, 8'(b << 4), 8'(v ^ 8'h5A), 8'h00, 4'h0, 8'(v), 8'h00,
              1'b0, "R5 acc bit");

    // R6: memory bit test, 3-byte base, offset in op2
    for (int b = 0; b < 16; b++)
      for (int v = 0; v < 256; v++)
        apply(3'd3, 16'(16'hFF00 + v), 8'(b << 4), 8'h11, 8'(v * 3), 4'h0, 8'h00, 8'(v),
              1'b0, "R6 mem bit");

    // R7: fused forms, both lengths, both zero results
    for (int z = 0; z < 2; z++)
      for (int r = 0; r < 256; r++) begin
        apply(3'd4, 16'h2200, 8'h00, 8'h44, 8'(r), 4'h0, 8'h00, 8'h00, 1'(z), "R7 fused3");
        apply(3'd5, 16'h2200, 8'h00, 8'(r), 8'h44, 4'h0, 8'h00, 8'h00, 1'(z), "R7 fused2");
      end

    // R8: upper-page call
    for (int r = 0; r < 256; r++)
      apply(3'd6, 16'(16'h7000 + r), 8'h4F, 8'(r), 8'h99, 4'hF, 8'h00, 8'h00, 1'b1, "R8 upage");

    // R9: every table slot
    for (int n = 0; n < 16; n++)
      apply(3'd7, 16'h0450, 8'((n << 4) | 10), 8'h00, 8'h00, 4'h0, 8'h00, 8'h00, 1'b0,
            "R9 vector");

    // R1: no strobe, inputs change, results must hold
    inValid = 1'b0; inKind = 3'd6; op1 = 8'h77; pc = 16'h0001;
    @(negedge clk);
    check("R1 hold", {outValid, outTaken, outTarget}, {1'b0, 1'b1, lastTarget});
    inKind = 3'd0; opcode = 8'h00; flagN = 1'b1;
    @(negedge clk);
    check("R1 hold2", {outValid, outTaken, outTarget}, {1'b0, 1'b1, lastTarget});

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule